// File: doc/BRIEF.md
# Streaming 256-Point Number-Theoretic Transform Engine

This block computes the forward or inverse negacyclic number-theoretic transform of a 256-coefficient polynomial over the prime field of 3329. Its output is the seven-layer incomplete form, so pairs of coefficients are left untransformed. Coefficients enter one per transfer on a valid/ready input stream and are kept in an internal 256 x 12-bit register file. The engine then runs seven layers of 128 butterflies, one butterfly per clock. Forward mode uses Cooley-Tukey butterflies and inverse mode uses Gentleman-Sande butterflies. Both modes share a single Barrett modular multiplier. The twiddle factors come from a 128-entry table held in bit-reversed order.

A one-cycle `start` pulse, taken while the engine is idle, latches the direction bit and opens the load phase. After 256 coefficients have been accepted, the transform runs by itself. In inverse mode it ends with a pass that multiplies every coefficient by 3303, which is the inverse of 128 modulo 3329. The results then leave on the output stream in index order, and a one-cycle `done` pulse closes the job.

Top module: `ntt_stream`

## Requirements
- R1: While reset is held and immediately after it, `in_ready`, `out_valid` and `done` are all 0.
- R2: A `start` pulse seen in the idle state latches `inverse` (1 = inverse transform), and `in_ready` is 1 in the next cycle. `start` and `inverse` are ignored in every other state.
- R3: `in_ready` is 1 only during the load phase. A coefficient is taken only in a cycle with `in_valid` and `in_ready` both 1. The 256 coefficients are stored at indices 0, 1, ..., 255 in arrival order, and each must be below 3329.
- R4: Forward mode computes the following. For span = 128, 64, ..., 2, groups are taken in ascending order, and each group uses the next twiddle, with the index counting up from 1. Each butterfly does t = w*f[j+span], f[j+span] = f[j]-t, f[j] = f[j]+t, all mod 3329.
- R5: Inverse mode computes the following. For span = 2, 4, ..., 128, groups are taken in ascending order, with the twiddle index counting down from 127. Each butterfly does s = f[j], f[j] = s+f[j+span], f[j+span] = w*(f[j+span]-s). Every result is then multiplied by 3303 mod 3329, so inverse(forward(x)) = x.
- R6: Twiddle entry i equals 17^rev7(i) mod 3329, where rev7 reverses the 7 bits of i.
- R7: `out_valid` first rises 896 clock edges after the edge that accepts the 256th coefficient in forward mode, and 1152 edges after it in inverse mode.
- R8: Results are presented on `out_data` in index order 0 to 255. A result advances only when `out_valid` and `out_ready` are both 1, and `out_data` is held stable while `out_ready` is 0.
- R9: `done` is 1 for exactly one cycle, in the cycle after the 256th output transfer. The engine is then idle, with `in_ready` and `out_valid` at 0.
- R10: Every value presented with `out_valid` is below 3329.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a job when idle |
| inverse | input | 1 | Direction, sampled with start: 0 forward, 1 inverse |
| in_valid | input | 1 | Input coefficient is valid |
| in_ready | output | 1 | Engine accepts a coefficient |
| in_data | input | 12 | Input coefficient, below 3329 |
| out_valid | output | 1 | Result coefficient is valid |
| out_ready | input | 1 | Sink accepts a result |
| out_data | output | 12 | Result coefficient |
| done | output | 1 | One-cycle end-of-job pulse |

## Verification
A control fault, such as a layer or butterfly counter that steps wrongly or a phase that is skipped, moves the edges of `in_ready`, `out_valid` or `done`. The cycle-accurate model in the bench flags such a fault in the very cycle the handshake diverges. A datapath fault, such as a wrong twiddle index, a wrong pair address, a swapped butterfly form or a missing final scale, leaves the handshake timing intact. It shows up only during unload, as mismatching coefficients, and usually in many positions at once. The inverse-after-forward round trip checks both directions against the original input, independently of the twiddle table the bench builds.

// File: rtl/ntt_pkg.sv
package ntt_pkg;
    localparam int unsigned CW   = 12;
    localparam int unsigned Q    = 3329;
    localparam int unsigned NC   = 256;
    localparam int unsigned NB   = NC / 2;
    localparam int unsigned IW   = $clog2(NC);
    localparam int unsigned TW   = $clog2(NB);
    localparam int unsigned NL   = TW;
    localparam int unsigned ROOT = 17;

    typedef logic [CW-1:0] coef_t;

    typedef enum logic [2:0] {
        S_IDLE, S_LOAD, S_COMP, S_SCALE, S_OUT, S_DONE
    } state_t;

    function automatic int unsigned pow_mod(int unsigned base, int unsigned e);
        int unsigned r = 1;
        int unsigned b = base % Q;
        int unsigned k = e;
        while (k != 0) begin
            if (k[0]) r = (r * b) % Q;
            b = (b * b) % Q;
            k = k >> 1;
        end
        return r;
    endfunction

    function automatic int unsigned bit_rev(int unsigned v, int unsigned bits);
        int unsigned r = 0;
        for (int unsigned i = 0; i < bits; i++)
            if (v[i]) r = r | (1 << (bits - 1 - i));
        return r;
    endfunction

    function automatic coef_t zeta_val(int unsigned i);
        return coef_t'(pow_mod(ROOT, bit_rev(i, TW)));
    endfunction

    localparam coef_t NINV = coef_t'(pow_mod(NB, Q - 2));

    function automatic coef_t add_mod(coef_t a, coef_t b);
        logic [CW:0] s;
        s = {1'b0, a} + {1'b0, b};
        return (s >= (CW+1)'(Q)) ? coef_t'(s - (CW+1)'(Q)) : coef_t'(s);
    endfunction

    function automatic coef_t sub_mod(coef_t a, coef_t b);
        logic [CW:0] s;
        s = (a >= b) ? ({1'b0, a} - {1'b0, b}) : ({1'b0, a} + (CW+1)'(Q) - {1'b0, b});
        return coef_t'(s);
    endfunction
endpackage

// File: rtl/ntt_mulmod.sv
module ntt_mulmod
    import ntt_pkg::*;
(
    input  coef_t x,
    input  coef_t y,
    output coef_t z
);
    localparam int unsigned PW = 2 * CW;
    localparam int unsigned KB = (1 << PW) / Q;
    localparam int unsigned XW = PW + $clog2(KB) + 1;
    localparam int unsigned TQ = PW - CW + 1;

    logic [PW-1:0] prod;
    logic [TQ-1:0] quot;
    logic [PW:0]   rem0;
    logic [PW:0]   rem1;

    always_comb begin
        prod = PW'(x) * PW'(y);
        quot = TQ'((XW'(prod) * XW'(KB)) >> PW);
        rem0 = (PW+1)'(prod) - (PW+1)'(quot) * (PW+1)'(Q);
        rem1 = (rem0 >= (PW+1)'(Q)) ? rem0 - (PW+1)'(Q) : rem0;
        z    = coef_t'((rem1 >= (PW+1)'(Q)) ? rem1 - (PW+1)'(Q) : rem1);
    end
endmodule

// File: rtl/ntt_bfly.sv
module ntt_bfly
    import ntt_pkg::*;
(
    input  logic  gs_mode,
    input  coef_t a,
    input  coef_t b,
    input  coef_t w,
    output coef_t ya,
    output coef_t yb
);
    coef_t diff, mul_in, prod;

    assign diff   = sub_mod(b, a);
    assign mul_in = gs_mode ? diff : b;

    ntt_mulmod u_mul (
        .x (w),
        .y (mul_in),
        .z (prod)
    );

    assign ya = add_mod(a, gs_mode ? b : prod);
    assign yb = gs_mode ? prod : sub_mod(a, prod);
endmodule

// File: rtl/ntt_twiddle.sv
module ntt_twiddle
    import ntt_pkg::*;
(
    input  logic [TW-1:0] idx,
    output coef_t         w
);
    coef_t table_w [NB];

    for (genvar i = 0; i < NB; i++) begin : g_tab
        localparam coef_t ZV = zeta_val(i);
        assign table_w[i] = ZV;
    end

    assign w = table_w[idx];
endmodule

// File: rtl/ntt_stream.sv
module ntt_stream
    import ntt_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          inverse,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [CW-1:0] in_data,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [CW-1:0] out_data,
    output logic          done
);
    localparam int unsigned LW = $clog2(NL);

    typedef struct packed {
        state_t        st;
        logic          inv;
        logic [LW-1:0] layer;
        logic [IW-1:0] cnt;
    } ctl_t;

    ctl_t  ctl_d, ctl_q;
    coef_t rf_q [NC];

    logic          wa_en, wb_en;
    logic [IW-1:0] wa_idx, wb_idx;
    coef_t         wa_val;

    logic [3:0]    span_sh;
    logic [IW-1:0] span, bidx, grp, pos_a, pos_b, kf, ki;
    logic [TW-1:0] tw_idx;
    coef_t         tw_w, bf_a, bf_b, bf_w, bf_ya, bf_yb;
    logic          bf_gs;

    // butterfly addressing for the current layer and butterfly count
    always_comb begin
        span_sh = ctl_q.inv ? 4'(ctl_q.layer) + 4'd1 : 4'(TW) - 4'(ctl_q.layer);
        span    = IW'(1) << span_sh;
        bidx    = IW'(ctl_q.cnt[TW-1:0]);
        grp     = bidx >> span_sh;
        pos_a   = IW'(grp << (span_sh + 4'd1)) | (bidx & (span - IW'(1)));
        pos_b   = pos_a | span;
        kf      = (IW'(1) << ctl_q.layer) + grp;
        ki      = (IW'(NB) >> ctl_q.layer) - IW'(1) - grp;
        tw_idx  = ctl_q.inv ? ki[TW-1:0] : kf[TW-1:0];
    end

    ntt_twiddle u_tw (
        .idx (tw_idx),
        .w   (tw_w)
    );

    // the scale pass runs through the inverse butterfly with a zero upper input
    always_comb begin
        if (ctl_q.st == S_SCALE) begin
            bf_gs = 1'b1;
            bf_a  = '0;
            bf_b  = rf_q[ctl_q.cnt];
            bf_w  = NINV;
        end else begin
            bf_gs = ctl_q.inv;
            bf_a  = rf_q[pos_a];
            bf_b  = rf_q[pos_b];
            bf_w  = tw_w;
        end
    end

    ntt_bfly u_bf (
        .gs_mode (bf_gs),
        .a       (bf_a),
        .b       (bf_b),
        .w       (bf_w),
        .ya      (bf_ya),
        .yb      (bf_yb)
    );

    always_comb begin
        ctl_d  = ctl_q;
        wa_en  = 1'b0;
        wb_en  = 1'b0;
        wa_idx = ctl_q.cnt;
        wb_idx = pos_b;
        wa_val = in_data;
        unique case (ctl_q.st)
            S_IDLE: begin
                if (start) begin
                    ctl_d.st  = S_LOAD;
                    ctl_d.inv = inverse;
                    ctl_d.cnt = '0;
                end
            end
            S_LOAD: begin
                if (in_valid) begin
                    wa_en     = 1'b1;
                    ctl_d.cnt = ctl_q.cnt + IW'(1);
                    if (ctl_q.cnt == IW'(NC - 1)) begin
                        ctl_d.st    = S_COMP;
                        ctl_d.cnt   = '0;
                        ctl_d.layer = '0;
                    end
                end
            end
            S_COMP: begin
                wa_en     = 1'b1;
                wb_en     = 1'b1;
                wa_idx    = pos_a;
                wa_val    = bf_ya;
                ctl_d.cnt = ctl_q.cnt + IW'(1);
                if (ctl_q.cnt[TW-1:0] == TW'(NB - 1)) begin
                    ctl_d.cnt = '0;
                    if (ctl_q.layer == LW'(NL - 1))
                        ctl_d.st = ctl_q.inv ? S_SCALE : S_OUT;
                    else
                        ctl_d.layer = ctl_q.layer + LW'(1);
                end
            end
            S_SCALE: begin
                wa_en     = 1'b1;
                wa_val    = bf_yb;
                ctl_d.cnt = ctl_q.cnt + IW'(1);
                if (ctl_q.cnt == IW'(NC - 1)) ctl_d.st = S_OUT;
            end
            S_OUT: begin
                if (out_ready) begin
                    ctl_d.cnt = ctl_q.cnt + IW'(1);
                    if (ctl_q.cnt == IW'(NC - 1)) ctl_d.st = S_DONE;
                end
            end
            S_DONE:  ctl_d.st = S_IDLE;
            default: ctl_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{st: S_IDLE, inv: 1'b0, layer: '0, cnt: '0};
        else        ctl_q <= ctl_d;
    end

    always_ff @(posedge clk) begin
        if (wa_en) rf_q[wa_idx] <= wa_val;
        if (wb_en) rf_q[wb_idx] <= bf_yb;
    end

    assign in_ready  = (ctl_q.st == S_LOAD);
    assign out_valid = (ctl_q.st == S_OUT);
    assign out_data  = rf_q[ctl_q.cnt];
    assign done      = (ctl_q.st == S_DONE);

    // R3
    load_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !out_valid && !done);
    // R3
    load_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready && !in_valid |=> in_ready);
    // R8
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));
    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !in_ready && !out_valid);
    // R10
    out_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_data < CW'(Q));
endmodule

// File: tb/sim_ntt_stream.sv
module sim_ntt_stream;
    localparam int QM = 3329;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        inverse = 1'b0;
    logic        in_valid = 1'b0;
    logic        out_ready = 1'b0;
    logic [11:0] in_data = '0;
    logic        in_ready, out_valid, done;
    logic [11:0] out_data;

    always #4 clk = ~clk;

    ntt_stream u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .inverse   (inverse),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data),
        .done      (done)
    );

    int total = 0;
    int bad = 0;
    bit fin = 1'b0;
    int src[256], keep[256], cap[256], golden[256], got[256];
    int ph = 0;
    int ld = 0;
    int oc = 0;
    int wt = 0;
    bit m_inv = 1'b0;
    bit run_done = 1'b0;
    bit out_gap = 1'b0;
    bit last_hold = 1'b0;
    int last_od = 0;

    task automatic chk(bit ok, string tag, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int zeta(int i);
        int e = 0;
        int r = 1;
        for (int b = 0; b < 7; b++) if ((i >> b) & 1) e += 1 << (6 - b);
        for (int k = 0; k < e; k++) r = (r * 17) % QM;
        return r;
    endfunction

    // R4 R5 R6: software model of both transforms
    task automatic build_ref(bit inv);
        int f[256];
        int k, z, t;
        f = cap;
        if (!inv) begin
            k = 1;
            for (int len = 128; len >= 2; len = len / 2)
                for (int s = 0; s < 256; s += 2 * len) begin
                    z = zeta(k);
                    k++;
                    for (int j = s; j < s + len; j++) begin
                        t = (z * f[j+len]) % QM;
                        f[j+len] = (f[j] - t + QM) % QM;
                        f[j] = (f[j] + t) % QM;
                    end
                end
        end else begin
            k = 127;
            for (int len = 2; len <= 128; len = len * 2)
                for (int s = 0; s < 256; s += 2 * len) begin
                    z = zeta(k);
                    k--;
                    for (int j = s; j < s + len; j++) begin
                        t = f[j];
                        f[j] = (t + f[j+len]) % QM;
                        f[j+len] = (z * ((f[j+len] - t + QM) % QM)) % QM;
                    end
                end
            for (int j = 0; j < 256; j++) f[j] = (f[j] * 3303) % QM;
        end
        golden = f;
    endtask

    // cycle model: 0 idle, 1 load, 2 compute, 3 unload, 4 done
    always @(negedge clk) begin
        if (rst_n && !fin) begin
            chk(in_ready === (ph == 1), "R2 R3 in_ready", int'(in_ready), int'(ph == 1));
            chk(out_valid === (ph == 3), "R7 R8 out_valid", int'(out_valid), int'(ph == 3));
            chk(done === (ph == 4), "R9 done", int'(done), int'(ph == 4));
            if (out_valid) chk(out_data < 12'd3329, "R10 range", int'(out_data), QM - 1);
            if (last_hold) chk(int'(out_data) == last_od, "R8 hold", int'(out_data), last_od);
            last_hold = out_valid && !out_ready;
            last_od = int'(out_data);
            case (ph)
                0: if (start) begin ph = 1; m_inv = inverse; ld = 0; end
                1: if (in_valid) begin
                    cap[ld] = int'(in_data);
                    ld++;
                    if (ld == 256) begin
                        build_ref(m_inv);
                        ph = 2;
                        wt = m_inv ? 1152 : 896;
                        oc = 0;
                    end
                end
                2: begin wt--; if (wt == 0) ph = 3; end
                3: if (out_ready) begin
                    chk(int'(out_data) == golden[oc], m_inv ? "R5 inverse data" : "R4 R6 forward data",
                        int'(out_data), golden[oc]);
                    got[oc] = int'(out_data);
                    oc++;
                    if (oc == 256) ph = 4;
                end
                4: begin ph = 0; run_done = 1'b1; end
                default: ph = 0;
            endcase
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            #2;
            out_ready = out_gap ? ($urandom_range(0, 1) == 1) : 1'b1;
        end
    end

    task automatic run(bit inv, bit gin, bit gout);
        bit acc;
        int i;
        out_gap = gout;
        run_done = 1'b0;
        @(posedge clk); #2;
        start = 1'b1;
        inverse = inv;
        @(posedge clk); #2;
        start = 1'b0;
        inverse = !inv;
        i = 0;
        while (i < 256) begin
            in_valid = gin ? ($urandom_range(0, 2) != 0) : 1'b1;
            in_data = 12'(src[i]);
            start = (i == 77); // R2: ignored while loading
            @(negedge clk);
            acc = in_valid && in_ready;
            @(posedge clk); #2;
            if (acc) i++;
        end
        in_valid = 1'b0;
        start = 1'b0;
        repeat (20) @(posedge clk);
        #2 start = 1'b1; // R2: ignored while computing
        @(posedge clk); #2 start = 1'b0;
        wait (run_done);
        @(posedge clk); #2;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        chk(!in_ready && !out_valid && !done, "R1 in reset", int'({in_ready, out_valid, done}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!in_ready && !out_valid && !done, "R1 after reset", int'({in_ready, out_valid, done}), 0);

        for (int i = 0; i < 256; i++) src[i] = int'($urandom_range(0, 3328));
        keep = src;
        run(1'b0, 1'b0, 1'b0);

        src = got;
        run(1'b1, 1'b1, 1'b1);
        for (int i = 0; i < 256; i++) chk(got[i] == keep[i], "R5 roundtrip", got[i], keep[i]);

        for (int i = 0; i < 256; i++) src[i] = QM - 1;
        run(1'b0, 1'b1, 1'b1);

        for (int i = 0; i < 256; i++) src[i] = int'($urandom_range(0, 3328));
        run(1'b1, 1'b0, 1'b0);

        fin = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!fin) begin
            fin = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", ph, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule